// File: doc/BRIEF.md
# Microprogrammed Three-Valued Temporal Monitor

This block evaluates a temporal property over a handful of boolean proposition inputs and reports a three-valued verdict: undecided, violated or satisfied. It has no fixed transitions. A small microprogram store holds the whole automaton, one word for every pair of current state and proposition vector. Each word gives the next state and the verdict code to report. A compiled monitor automaton is loaded through a configuration port, so the property can change at run time without rebuilding the hardware.

The monitor does not advance on every clock. It moves one step only when a step event arrives while the monitor is enabled, and it can accept one step per clock cycle. Each accepted step produces a one-cycle verdict-valid pulse. When a definite verdict is reached, the monitor freezes in that state until reset. The store can be written only while the monitor is disabled.

Top module: `mtm_monitor`

## Requirements
- R1: While `rst` is high, and in the cycle after it is sampled high, `state` is 0, `verdict` is 00 (undecided) and `verdict_valid` is low. Reset leaves the contents of the microprogram store unchanged.
- R2: The store is addressed by `{state, props}`, with the state in the upper bits. Each word holds a next-state field and a 2-bit verdict code. When a step is accepted at a clock edge, `state` and `verdict` show that word's fields immediately after that edge.
- R3: Verdict codes are 00 for undecided, 01 for violated and 10 for satisfied. A stored code of 11 is reported as 00, so `verdict` never reads 11.
- R4: A step is accepted only when `step_valid` and `enable` are both high at a clock edge. At any other edge, `state` and `verdict` keep their values and no valid pulse follows.
- R5: `verdict_valid` is high for exactly the cycle after each accepted step. Steps on consecutive cycles are each accepted, and the pulse then stays high for the same number of cycles.
- R6: Once `verdict` is 01 or 10, `state` and `verdict` stay frozen until reset. This holds whatever the store holds for the frozen state. Accepted steps still produce valid pulses.
- R7: A configuration write stores `{cfg_next_state, cfg_verdict}` at `cfg_addr` only when `enable` is low at the edge. A write attempted while `enable` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Monitor running; also locks the store against writes |
| step_valid | input | 1 | Step event; advances the monitor by one step |
| props | input | PROP_W | Proposition bits sampled with a step |
| cfg_we | input | 1 | Store write strobe |
| cfg_addr | input | STATE_W+PROP_W | Store address `{state, props}` |
| cfg_next_state | input | STATE_W | Next-state field to write |
| cfg_verdict | input | 2 | Verdict code to write |
| verdict_valid | output | 1 | Pulses in the cycle after each accepted step |
| verdict | output | 2 | Current verdict code |
| state | output | STATE_W | Current automaton state |

## Verification
The bench loads a test automaton and runs an exhaustive sweep over every reachable non-final state paired with every proposition vector. This separates ordinary moves, moves into a violated verdict, moves into a satisfied verdict, and the reserved code being reported as undecided. A long pseudo-random proposition stream with idle and disabled gaps checks back-to-back stepping and shows that unaccepted edges do nothing. It also checks that a final verdict stays frozen even though the store points that state back to state 0. Write attempts made while enabled and while disabled, followed by a reset, show that the write lock works and that reset leaves the loaded program in place.

// File: rtl/mtm_pkg.sv
package mtm_pkg;

    localparam int unsigned DEF_STATE_W = 3;
    localparam int unsigned DEF_PROP_W  = 2;
    localparam int unsigned VERD_W      = 2;

    typedef enum logic [VERD_W-1:0] {
        V_UNDEC = 2'b00,
        V_VIOL  = 2'b01,
        V_SAT   = 2'b10,
        V_RSVD  = 2'b11
    } verdict_e;

    // Reserved code folds to undecided.
    function automatic verdict_e decode_verdict(input logic [VERD_W-1:0] code);
        verdict_e v;
        case (code)
            2'b01:   v = V_VIOL;
            2'b10:   v = V_SAT;
            default: v = V_UNDEC;
        endcase
        return v;
    endfunction

    function automatic logic is_final(input verdict_e v);
        return (v == V_VIOL) || (v == V_SAT);
    endfunction

endpackage

// File: rtl/mtm_ustore.sv
module mtm_ustore #(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned WORD_W = 5
) (
    input  logic              clk,
    input  logic              lock,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    // Contents are not touched by reset: the program survives it.
    always_ff @(posedge clk) begin
        if (wr_req && !lock) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/mtm_sequencer.sv
module mtm_sequencer
    import mtm_pkg::*;
#(
    parameter int unsigned STATE_W    = 3,
    parameter int unsigned INIT_STATE = 0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                go,
    input  logic [STATE_W-1:0]  nxt_state,
    input  logic [VERD_W-1:0]   nxt_code,
    output logic [STATE_W-1:0]  cur_state,
    output verdict_e            cur_verdict,
    output logic                pulse
);
    logic frozen;
    assign frozen = is_final(cur_verdict);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_state   <= STATE_W'(INIT_STATE);
            cur_verdict <= V_UNDEC;
            pulse       <= 1'b0;
        end else begin
            pulse <= go;
            if (go && !frozen) begin
                cur_state   <= nxt_state;
                cur_verdict <= decode_verdict(nxt_code);
            end
        end
    end
endmodule

// File: rtl/mtm_monitor.sv
module mtm_monitor
    import mtm_pkg::*;
#(
    parameter int unsigned STATE_W    = DEF_STATE_W,
    parameter int unsigned PROP_W     = DEF_PROP_W,
    parameter int unsigned INIT_STATE = 0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       enable,
    input  logic                       step_valid,
    input  logic [PROP_W-1:0]          props,
    input  logic                       cfg_we,
    input  logic [STATE_W+PROP_W-1:0]  cfg_addr,
    input  logic [STATE_W-1:0]         cfg_next_state,
    input  logic [VERD_W-1:0]          cfg_verdict,
    output logic                       verdict_valid,
    output logic [VERD_W-1:0]          verdict,
    output logic [STATE_W-1:0]         state
);
    localparam int unsigned ADDR_W = STATE_W + PROP_W;
    localparam int unsigned WORD_W = STATE_W + VERD_W;

    logic [WORD_W-1:0] rd_word;
    logic [ADDR_W-1:0] rd_addr;
    verdict_e          verd_q;
    logic              go;

    assign rd_addr = {state, props};
    assign go      = step_valid && enable;

    mtm_ustore #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
        .clk     (clk),
        .lock    (enable),
        .wr_req  (cfg_we),
        .wr_addr (cfg_addr),
        .wr_data ({cfg_next_state, cfg_verdict}),
        .rd_addr (rd_addr),
        .rd_data (rd_word)
    );

    mtm_sequencer #(.STATE_W(STATE_W), .INIT_STATE(INIT_STATE)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .go          (go),
        .nxt_state   (rd_word[WORD_W-1:VERD_W]),
        .nxt_code    (rd_word[VERD_W-1:0]),
        .cur_state   (state),
        .cur_verdict (verd_q),
        .pulse       (verdict_valid)
    );

    assign verdict = verd_q;
endmodule

// File: rtl/mtm_monitor_chk.sv
module mtm_monitor_chk #(
    parameter int unsigned STATE_W    = 3,
    parameter int unsigned INIT_STATE = 0
) (
    input logic               clk,
    input logic               rst,
    input logic               enable,
    input logic               step_valid,
    input logic               verdict_valid,
    input logic [1:0]         verdict,
    input logic [STATE_W-1:0] state
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (state == STATE_W'(INIT_STATE)) && (verdict == 2'b00) && !verdict_valid);

    assert_no_reserved_code_R3: assert property (@(posedge clk) disable iff (rst)
        verdict != 2'b11);

    assert_idle_no_change_R4: assert property (@(posedge clk) disable iff (rst)
        !(step_valid && enable) |=> $stable(state) && $stable(verdict) && !verdict_valid);

    assert_pulse_follows_step_R5: assert property (@(posedge clk) disable iff (rst)
        verdict_valid |-> $past(step_valid && enable));

    assert_final_frozen_R6: assert property (@(posedge clk) disable iff (rst)
        (verdict != 2'b00) |=> $stable(state) && $stable(verdict));
endmodule

bind mtm_monitor mtm_monitor_chk #(.STATE_W(STATE_W), .INIT_STATE(INIT_STATE)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .enable        (enable),
    .step_valid    (step_valid),
    .verdict_valid (verdict_valid),
    .verdict       (verdict),
    .state         (state)
);

// File: tb/test_mtm_monitor.sv
module test_mtm_monitor;
    localparam int SW = 3;
    localparam int PW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          enable = 1'b0;
    logic          step_valid = 1'b0;
    logic [PW-1:0] props = '0;
    logic          cfg_we = 1'b0;
    logic [SW+PW-1:0] cfg_addr = '0;
    logic [SW-1:0] cfg_next_state = '0;
    logic [1:0]    cfg_verdict = '0;
    logic          verdict_valid;
    logic [1:0]    verdict;
    logic [SW-1:0] state;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    // Bench model state
    int ms;
    int mv;
    bit patched = 0;

    always #2 clk = ~clk;

    mtm_monitor i_mtm_monitor (
        .clk(clk), .rst(rst), .enable(enable), .step_valid(step_valid), .props(props),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_next_state(cfg_next_state),
        .cfg_verdict(cfg_verdict), .verdict_valid(verdict_valid), .verdict(verdict),
        .state(state)
    );

    // Test automaton: returns {next_state, code}
    function automatic int tbl(input int s, input int p);
        int ns;
        int code;
        if (patched && s == 0 && p == 1) begin ns = 4; code = 2; end
        else if (s >= 5) begin ns = 0; code = 0; end
        else if (s == 4 && p == 3) begin ns = 5; code = 1; end
        else if (s == 3 && p == 2) begin ns = 6; code = 2; end
        else if (s == 2 && p == 1) begin ns = 3; code = 3; end
        else begin ns = (s + p) % 5; code = 0; end
        return ns * 4 + code;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_word(input int a, input int ns, input int code);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = (SW+PW)'(a);
        cfg_next_state = SW'(ns); cfg_verdict = 2'(code);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        ms = 0; mv = 0;
    endtask

    task automatic model_step(input int p);
        int w;
        if (mv == 0) begin
            w = tbl(ms, p);
            ms = w / 4;
            mv = ((w % 4) == 3) ? 0 : (w % 4);
        end
    endtask

    // One accepted step, checked after the edge
    task automatic step_chk(input int p, input string req);
        @(negedge clk);
        step_valid = 1'b1; props = PW'(p);
        @(negedge clk);
        step_valid = 1'b0;
        model_step(p);
        chk(state == SW'(ms), req, int'(state), ms);
        chk(verdict == 2'(mv), req, int'(verdict), mv);
        chk(verdict_valid == 1'b1, "R5", int'(verdict_valid), 1);
    endtask

    initial begin
        // Program the store while disabled (R7)
        @(negedge clk); @(negedge clk);
        for (int a = 0; a < 32; a++) begin
            write_word(a, tbl(a / 4, a % 4) / 4, tbl(a / 4, a % 4) % 4);
        end
        do_reset();
        chk(state == 0 && verdict == 0 && !verdict_valid, "R1", int'(state) + int'(verdict), 0);
        enable = 1'b1;

        // Exhaustive sweep of non-final states and proposition vectors (R2, R3, R6)
        for (int s = 0; s < 5; s++) begin
            for (int p = 0; p < 4; p++) begin
                do_reset();
                if (s >= 1 && s <= 3) step_chk(s, "R2");
                if (s == 4) begin step_chk(3, "R2"); step_chk(1, "R2"); end
                chk(state == SW'(s), "R2", int'(state), s);
                step_chk(p, (s == 2 && p == 1) ? "R3" : "R2");
                if (mv != 0) begin
                    step_chk(0, "R6");
                    step_chk(3, "R6");
                    chk(state != 0, "R6", int'(state), ms);
                end
            end
        end

        // Back-to-back stream with gaps (R4, R5)
        begin
            logic [7:0] lfsr = 8'hA5;
            int p;
            do_reset();
            for (int i = 0; i < 300; i++) begin
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                p = int'(lfsr[1:0]);
                @(negedge clk);
                if (lfsr[7:5] == 3'b000) begin
                    step_valid = 1'b0; enable = 1'b1;
                end else if (lfsr[7:5] == 3'b001) begin
                    step_valid = 1'b1; enable = 1'b0;
                end else begin
                    step_valid = 1'b1; enable = 1'b1;
                end
                props = PW'(p);
                @(posedge clk);
                if (step_valid && enable) model_step(p);
                #1;
                if (lfsr[7:5] <= 3'b001) begin
                    chk(verdict_valid == 1'b0, "R4", int'(verdict_valid), 0);
                    chk(state == SW'(ms), "R4", int'(state), ms);
                end else begin
                    chk(verdict_valid == 1'b1, "R5", int'(verdict_valid), 1);
                    chk(state == SW'(ms) && verdict == 2'(mv), "R5", int'(state), ms);
                end
                if (mv != 0 && lfsr[2]) begin
                    @(negedge clk); step_valid = 1'b0; enable = 1'b1;
                    do_reset();
                end
            end
            @(negedge clk); step_valid = 1'b0; enable = 1'b1;
            @(negedge clk);
            chk(verdict_valid == 1'b0, "R5", int'(verdict_valid), 0);
        end

        // Write lock (R7) and reset keeps program (R1)
        do_reset();
        enable = 1'b1;
        write_word(1, 4, 2);
        step_chk(1, "R7");
        chk(state == 1 && verdict == 0, "R7", int'(state), 1);
        enable = 1'b0;
        write_word(1, 4, 2);
        patched = 1;
        do_reset();
        enable = 1'b1;
        step_chk(1, "R1");
        chk(state == 4 && verdict == 2, "R7", int'(state), 4);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule